// File: doc/BRIEF.md
# Store-Zero Address and Bus Sequencer

This block carries out the store-zero operation of a 16-bit processor core that addresses a banked 24-bit space. It is given the opcode of a store-zero instruction and its operand. It also receives the current direct-page base, the data bank, the X index and the two width flags. From these it forms the effective address for one of four addressing forms. It spends any internal idle cycles the addressing form costs, then issues one or two byte-wide writes of zero on a simple synchronous write bus.

A sequencer upstream raises `start_i` for one cycle, with all operands stable in that cycle. The block is busy until it raises `done_o` for one cycle. That cycle follows the last write. `start_i` is only taken while the block is idle and the opcode is one of the four it knows.

Top module: `stz_seq`

## Requirements
- R1: Opcode 0x64 (direct): the address is {8'h00, (dp + operand[7:0]) mod 2^16}.
- R2: Opcode 0x74 (direct indexed): the address is {8'h00, (dp + operand[7:0] + X) mod 2^16}.
- R3: Opcode 0x9C (absolute): the address is {dbr, operand[15:0]}, and the direct-page base has no effect on address or timing.
- R4: Opcode 0x9E (absolute indexed): the address is ({dbr, operand} + X) mod 2^24, so a carry may cross into the next bank.
- R5: For opcodes 0x64 and 0x74 only, one internal cycle is added when dp[7:0] is nonzero.
- R6: For opcodes 0x74 and 0x9E, one further internal cycle is added before the first write.
- R7: When `mem8_i` is 1, exactly one write cycle occurs. When it is 0, two consecutive writes occur. The first goes to the effective address. The second goes to {same bank byte, (low 16 bits + 1) mod 2^16}.
- R8: `wr_en_o` is high only in write cycles, one byte per cycle. `wr_data_o` is zero whenever `wr_en_o` is high. Internal cycles have `wr_en_o` low and `busy_o` high.
- R9: The first internal or write cycle is the cycle after `start_i` is taken. `done_o` is high for exactly one cycle, the one right after the last write. `busy_o` is low from the following cycle.
- R10: When `idx8_i` is 1, only X[7:0], zero-extended, enters the address sum.
- R11: `start_i` with an opcode outside {0x64, 0x74, 0x9C, 0x9E} is ignored. `start_i` while busy is ignored and does not change the running operation.
- R12: While `rst_n` is low, `busy_o`, `wr_en_o` and `done_o` are low. Reset assertion takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, sampled when idle |
| opcode_i | input | 8 | Store-zero opcode selecting the addressing form |
| operand_i | input | 16 | Instruction operand (low byte only for direct forms) |
| dp_i | input | 16 | Direct-page base register |
| dbr_i | input | 8 | Data bank register |
| x_i | input | 16 | X index register |
| mem8_i | input | 1 | 1 = 8-bit memory width, 0 = 16-bit |
| idx8_i | input | 1 | 1 = 8-bit index registers |
| busy_o | output | 1 | Operation in progress |
| wr_en_o | output | 1 | Bus write strobe |
| addr_o | output | 24 | Bus address, valid while `wr_en_o` is high |
| wr_data_o | output | 8 | Bus write data, always zero |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the wrap points. A direct sum that overflows 16 bits must stay in bank 0, while an absolute indexed sum that overflows must move into the next bank or wrap to bank 0 at the top. A second byte at offset 0xFFFF must wrap to 0x0000 with the bank held; a design that carried would write into the wrong bank. Idle-cycle counts are probed with nonzero and zero direct-page low bytes in every form, and with indexing. Any error there shifts the first write by one cycle. Indexing with an 8-bit X whose high byte is nonzero exposes a design that fails to truncate the index. Unknown opcodes and a start held during an operation expose a design that launches spurious writes.

// File: rtl/stz_pkg.sv
package stz_pkg;

  typedef enum logic [1:0] {
    AM_DIR  = 2'd0,
    AM_DIRX = 2'd1,
    AM_ABS  = 2'd2,
    AM_ABSX = 2'd3
  } amode_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WAIT  = 3'd1,
    PH_WR_LO = 3'd2,
    PH_WR_HI = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

  localparam logic [7:0] OPC_STZ_DIR  = 8'h64;
  localparam logic [7:0] OPC_STZ_DIRX = 8'h74;
  localparam logic [7:0] OPC_STZ_ABS  = 8'h9C;
  localparam logic [7:0] OPC_STZ_ABSX = 8'h9E;

endpackage

// File: rtl/stz_decode.sv
module stz_decode
  import stz_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opcode_i,
  output logic             valid_o,
  output amode_e           mode_o,
  output logic             direct_o,
  output logic             indexed_o
);

  always_comb begin
    valid_o = 1'b1;
    mode_o  = AM_DIR;
    unique case (opcode_i)
      OPC_STZ_DIR:  mode_o = AM_DIR;
      OPC_STZ_DIRX: mode_o = AM_DIRX;
      OPC_STZ_ABS:  mode_o = AM_ABS;
      OPC_STZ_ABSX: mode_o = AM_ABSX;
      default:      valid_o = 1'b0;
    endcase
  end

  assign direct_o  = (mode_o == AM_DIR) || (mode_o == AM_DIRX);
  assign indexed_o = (mode_o == AM_DIRX) || (mode_o == AM_ABSX);

endmodule

// File: rtl/stz_addr_gen.sv
module stz_addr_gen
  import stz_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BANK_W = 8,
  parameter int CNT_W  = 2
) (
  input  amode_e                    mode_i,
  input  logic                      direct_i,
  input  logic                      indexed_i,
  input  logic [WORD_W-1:0]         operand_i,
  input  logic [WORD_W-1:0]         dp_i,
  input  logic [BANK_W-1:0]         dbr_i,
  input  logic [WORD_W-1:0]         x_i,
  input  logic                      idx8_i,
  output logic [WORD_W+BANK_W-1:0]  ea_o,
  output logic [CNT_W-1:0]          idle_cnt_o
);

  localparam int ADDR_W = WORD_W + BANK_W;
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] x_eff;
  logic [WORD_W-1:0] dp_sum;
  logic [WORD_W-1:0] dpx_sum;
  logic [ADDR_W-1:0] abs_addr;
  logic [ADDR_W-1:0] absx_addr;
  logic              dp_lo_nz;

  // narrow index: high half forced to zero
  assign x_eff = idx8_i ? {{(WORD_W-HALF_W){1'b0}}, x_i[HALF_W-1:0]} : x_i;

  // direct forms wrap inside 16 bits
  assign dp_sum  = dp_i + {{(WORD_W-HALF_W){1'b0}}, operand_i[HALF_W-1:0]};
  assign dpx_sum = dp_sum + x_eff;

  // absolute forms: bank prepended; indexed sum carries into bank
  assign abs_addr  = {dbr_i, operand_i};
  assign absx_addr = abs_addr + {{BANK_W{1'b0}}, x_eff};

  always_comb begin
    unique case (mode_i)
      AM_DIR:  ea_o = {{BANK_W{1'b0}}, dp_sum};
      AM_DIRX: ea_o = {{BANK_W{1'b0}}, dpx_sum};
      AM_ABS:  ea_o = abs_addr;
      default: ea_o = absx_addr;
    endcase
  end

  assign dp_lo_nz   = |dp_i[HALF_W-1:0];
  assign idle_cnt_o = CNT_W'(direct_i && dp_lo_nz) + CNT_W'(indexed_i);

endmodule

// File: rtl/stz_bus_fsm.sv
module stz_bus_fsm
  import stz_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [CNT_W-1:0] idle_cnt_i,
  input  logic             wide_i,
  output phase_e           phase_o,
  output logic             ready_o,
  output logic             wide_o
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             wide_q;
  logic             wide_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    wide_en = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (go_i) begin
          wide_en = 1'b1;
          if (idle_cnt_i != '0) begin
            phase_d = PH_WAIT;
            cnt_en  = 1'b1;
            cnt_d   = idle_cnt_i - 1'b1;
          end else begin
            phase_d = PH_WR_LO;
          end
        end
      end
      PH_WAIT: begin
        if (cnt_q == '0) begin
          phase_d = PH_WR_LO;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end
      PH_WR_LO: phase_d = wide_q ? PH_WR_HI : PH_DONE;
      PH_WR_HI: phase_d = PH_DONE;
      PH_DONE:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
    end else if (wide_en) begin
      wide_q <= wide_i;
    end
  end

  assign phase_o = phase_q;
  assign ready_o = (phase_q == PH_IDLE);
  assign wide_o  = wide_q;

  // R6: the last internal cycle is always followed by the first write
  assert_wait_leads_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && cnt_q == '0) |=> (phase_q == PH_WR_LO));

  // R11: a running operation cannot fall back to idle except through done
  assert_no_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && phase_q != PH_DONE) |=> (phase_q != PH_IDLE));

  // R9: completion lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/stz_seq.sv
module stz_seq
  import stz_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BANK_W = 8,
  parameter int OPC_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [OPC_W-1:0]         opcode_i,
  input  logic [WORD_W-1:0]        operand_i,
  input  logic [WORD_W-1:0]        dp_i,
  input  logic [BANK_W-1:0]        dbr_i,
  input  logic [WORD_W-1:0]        x_i,
  input  logic                     mem8_i,
  input  logic                     idx8_i,
  output logic                     busy_o,
  output logic                     wr_en_o,
  output logic [WORD_W+BANK_W-1:0] addr_o,
  output logic [DATA_W-1:0]        wr_data_o,
  output logic                     done_o
);

  localparam int ADDR_W  = WORD_W + BANK_W;
  localparam int CNT_W   = 2;
  localparam int SYNC_W  = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_W-1];

  logic             dec_valid;
  amode_e           dec_mode;
  logic             dec_direct;
  logic             dec_indexed;
  logic [ADDR_W-1:0] ea;
  logic [CNT_W-1:0] idle_cnt;
  phase_e           phase;
  logic             ready;
  logic             wide;
  logic             go;

  stz_decode #(.OPC_W(OPC_W)) u_decode (
    .opcode_i  (opcode_i),
    .valid_o   (dec_valid),
    .mode_o    (dec_mode),
    .direct_o  (dec_direct),
    .indexed_o (dec_indexed)
  );

  stz_addr_gen #(.WORD_W(WORD_W), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_addr (
    .mode_i     (dec_mode),
    .direct_i   (dec_direct),
    .indexed_i  (dec_indexed),
    .operand_i  (operand_i),
    .dp_i       (dp_i),
    .dbr_i      (dbr_i),
    .x_i        (x_i),
    .idx8_i     (idx8_i),
    .ea_o       (ea),
    .idle_cnt_o (idle_cnt)
  );

  assign go = start_i && dec_valid && ready;

  stz_bus_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .go_i       (go),
    .idle_cnt_i (idle_cnt),
    .wide_i     (!mem8_i),
    .phase_o    (phase),
    .ready_o    (ready),
    .wide_o     (wide)
  );

  // effective address captured with the start
  logic [ADDR_W-1:0] addr_q;
  logic              direct_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q   <= '0;
      direct_q <= 1'b0;
    end else if (go) begin
      addr_q   <= ea;
      direct_q <= dec_direct;
    end
  end

  // second byte: low word incremented, bank byte untouched
  logic [ADDR_W-1:0] addr_hi;
  assign addr_hi = {addr_q[ADDR_W-1:WORD_W], addr_q[WORD_W-1:0] + WORD_W'(1)};

  assign addr_o    = (phase == PH_WR_HI) ? addr_hi : addr_q;
  assign wr_en_o   = (phase == PH_WR_LO) || (phase == PH_WR_HI);
  assign wr_data_o = '0;
  assign done_o    = (phase == PH_DONE);
  assign busy_o    = !ready;

  // R9: done comes straight after a write and carries none itself
  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> ($past(wr_en_o) && !wr_en_o));

  // R7: back-to-back writes step the low word by one, bank held
  assert_hi_addr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en_o && $past(wr_en_o)) |->
      (addr_o[ADDR_W-1:WORD_W] == $past(addr_o[ADDR_W-1:WORD_W]) &&
       addr_o[WORD_W-1:0] == $past(addr_o[WORD_W-1:0]) + WORD_W'(1)));

  // R7: narrow store is a single write
  assert_narrow_single_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en_o && !wide) |=> !wr_en_o);

  // R1: direct forms never leave bank zero on the first byte
  assert_direct_bank0_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase == PH_WR_LO && direct_q) |-> (addr_o[ADDR_W-1:WORD_W] == '0));

  // R8: write strobe only while busy
  assert_write_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en_o |-> busy_o);

endmodule

// File: tb/stz_seq_test.sv
`timescale 1ns/1ps
module stz_seq_test;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  opcode_i;
  logic [15:0] operand_i;
  logic [15:0] dp_i;
  logic [7:0]  dbr_i;
  logic [15:0] x_i;
  logic        mem8_i;
  logic        idx8_i;
  logic        busy_o;
  logic        wr_en_o;
  logic [23:0] addr_o;
  logic [7:0]  wr_data_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;

  stz_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .operand_i(operand_i), .dp_i(dp_i), .dbr_i(dbr_i), .x_i(x_i),
    .mem8_i(mem8_i), .idx8_i(idx8_i), .busy_o(busy_o), .wr_en_o(wr_en_o),
    .addr_o(addr_o), .wr_data_o(wr_data_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] opnd;
    logic [15:0] dp;
    logic [7:0]  dbr;
    logic [15:0] x;
    logic        m8;
    logic        x8;
    logic [23:0] a1;
    logic [23:0] a2;
    logic [1:0]  idle;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h64, 16'h0012, 16'h0000, 8'h7E, 16'h0000, 1'b1, 1'b1, 24'h000012, 24'h000000, 2'd0},
    '{8'h64, 16'h0012, 16'h1201, 8'h7E, 16'h0000, 1'b0, 1'b1, 24'h001213, 24'h001214, 2'd1},
    '{8'h64, 16'h00F0, 16'hFF80, 8'h7E, 16'h0000, 1'b0, 1'b1, 24'h000070, 24'h000071, 2'd1},
    '{8'h64, 16'h00FF, 16'hFF00, 8'h7E, 16'h0000, 1'b0, 1'b1, 24'h00FFFF, 24'h000000, 2'd0},
    '{8'h74, 16'h0010, 16'h0100, 8'h7E, 16'h0005, 1'b1, 1'b1, 24'h000115, 24'h000000, 2'd1},
    '{8'h74, 16'h0020, 16'hFFF0, 8'h7E, 16'h1234, 1'b0, 1'b0, 24'h001244, 24'h001245, 2'd2},
    '{8'h74, 16'h0001, 16'h0000, 8'h7E, 16'h12FF, 1'b1, 1'b1, 24'h000100, 24'h000000, 2'd1},
    '{8'h9C, 16'hABCD, 16'h0033, 8'h12, 16'h0000, 1'b1, 1'b1, 24'h12ABCD, 24'h000000, 2'd0},
    '{8'h9C, 16'hFFFF, 16'h0000, 8'h05, 16'h0000, 1'b0, 1'b1, 24'h05FFFF, 24'h050000, 2'd0},
    '{8'h9E, 16'hFFF0, 16'h0044, 8'h05, 16'h0020, 1'b0, 1'b0, 24'h060010, 24'h060011, 2'd1},
    '{8'h9E, 16'hFFFF, 16'h0000, 8'hFF, 16'h0001, 1'b0, 1'b0, 24'h000000, 24'h000001, 2'd1},
    '{8'h9E, 16'h1000, 16'h0000, 8'h01, 16'hAB80, 1'b1, 1'b1, 24'h011080, 24'h000000, 2'd1},
    '{8'h9E, 16'h00FF, 16'h0000, 8'h33, 16'hFF01, 1'b0, 1'b0, 24'h340000, 24'h340001, 2'd1}
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string addr_tag(input vec_t v);
    if ((v.op == 8'h74 || v.op == 8'h9E) && v.x8 && v.x[15:8] != 8'h00) return "R10";
    case (v.op)
      8'h64:   return "R1";
      8'h74:   return "R2";
      8'h9C:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic drive(input vec_t v);
    opcode_i  = v.op;
    operand_i = v.opnd;
    dp_i      = v.dp;
    dbr_i     = v.dbr;
    x_i       = v.x;
    mem8_i    = v.m8;
    idx8_i    = v.x8;
  endtask

  // start one vector; hold start with another opcode for 'extra' busy cycles
  task automatic run_vec(input vec_t v, input int extra);
    logic        t_wr [8];
    logic        t_done [8];
    logic        t_busy [8];
    logic [23:0] t_addr [8];
    logic [7:0]  t_data [8];
    int fw;
    int nw;
    int nd;
    int nb;
    @(negedge clk);
    drive(v);
    start_i = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      t_wr[c]   = wr_en_o;
      t_done[c] = done_o;
      t_busy[c] = busy_o;
      t_addr[c] = addr_o;
      t_data[c] = wr_data_o;
      if (c < extra) begin
        start_i   = 1'b1;
        opcode_i  = 8'h9C;
        operand_i = 16'h5555;
      end else begin
        start_i = 1'b0;
      end
    end
    fw = -1;
    nw = 0;
    nd = 0;
    for (int c = 7; c >= 0; c--) if (t_wr[c]) fw = c;
    for (int c = 0; c < 8; c++) begin
      if (t_wr[c]) nw++;
      if (t_done[c]) nd++;
      if (t_wr[c] && t_data[c] != 8'h00) nd = nd + 100;
    end
    nb = v.m8 ? 1 : 2;
    chk(t_busy[0], "R9", "busy in first cycle", 32'(t_busy[0]), 1);
    chk(fw == int'(v.idle), "R5 R6", "internal cycles before write", 32'(fw), 32'(v.idle));
    if (fw >= 0) begin
      chk(t_addr[fw] == v.a1, addr_tag(v), "first address", 32'(t_addr[fw]), 32'(v.a1));
      chk(nw == nb, "R7", "write count", 32'(nw), 32'(nb));
      if (nb == 2 && fw < 7)
        chk(t_wr[fw+1] && t_addr[fw+1] == v.a2, "R7", "second address",
            32'(t_addr[fw+1]), 32'(v.a2));
      if (fw + nb < 7) begin
        chk(t_done[fw+nb], "R9", "done after last write", 32'(t_done[fw+nb]), 1);
        chk(!t_busy[fw+nb+1], "R9 R11", "idle after done", 32'(t_busy[fw+nb+1]), 0);
      end
    end
    chk(nd == 1, "R8", "one done and zero data", 32'(nd), 1);
  endtask

  initial begin
    start_i = 1'b0;
    opcode_i = 8'h00; operand_i = '0; dp_i = '0; dbr_i = '0; x_i = '0;
    mem8_i = 1'b1; idx8_i = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!busy_o && !wr_en_o && !done_o && wr_data_o == 8'h00, "R12", "reset outputs",
        {busy_o, wr_en_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 0);

    // R11: start held while busy with another opcode; operation unchanged
    run_vec(VECS[5], 2);
    run_vec(VECS[8], 1);

    // R11: unknown opcode launches nothing
    @(negedge clk);
    drive(VECS[0]);
    opcode_i = 8'hA5;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 4; c++) begin
      chk(!busy_o && !wr_en_o && !done_o, "R11", "unknown opcode ignored",
          {busy_o, wr_en_o, done_o}, 0);
      @(negedge clk);
    end

    // R12: asynchronous reset mid-operation
    drive(VECS[5]);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R12", "busy before reset", 32'(busy_o), 1);
    #1 rst_n = 1'b0;
    #1 chk(!busy_o && !wr_en_o && !done_o, "R12", "async reset clears",
           {busy_o, wr_en_o, done_o}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_vec(VECS[2], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule